// File: doc/BRIEF.md
# Bus Ownership Status Arbiter

This block decides which controller currently drives a shared control bus and publishes that decision as a two-bit status code. The console moves the machine between halt, single-step and free-running modes. While the machine runs and interrupts are enabled, an interrupt request takes the bus away from the instruction-decode controllers. The arbiter then stays in a negotiation state until the interrupt controller acknowledges, and returns to run mode after that. When the top status bit is low, the decode controllers see an inhibit and release the bus.

The same block holds an 8-bit condition-flag register. The flags are sticky. Data-path logic sets them through explicit set bits, or through a result stream whose value is checked for zero and for sign. A single clear strobe empties the whole register in one cycle.

The result stream uses a valid/ready pair. `res_ready` is high in every cycle outside reset, so the block applies no back-pressure. A result is taken on any clock edge at which both `res_valid` and `res_ready` are high. During reset `res_ready` is low and nothing is taken.

Top module: `opstat_arbiter`

## Requirements
- R1: A synchronous `rst` forces the status code {st1,st0} to 00 and clears all flags, and `irq_grant` reads low.
- R2: The status code means: 00 halt, 01 interrupt negotiation, 10 step mode, 11 run mode. From halt, `run_req` moves to 11 and `step_req` moves to 10. When both are requested together, run wins.
- R3: `halt_req` moves the code to 00 on the next edge from any state. It has priority over every other request.
- R4: `dec_inhibit` is high exactly when st1 is 0, that is, in halt and during negotiation.
- R5: An interrupt is accepted only when the code is 11, `irq_req` is high and `ie_n` is low (active low). On the next edge the code becomes 01 and `irq_grant` pulses high for that one cycle.
- R6: `irq_req` has no effect in states 00 and 10, or while `ie_n` is high. The code is unchanged and `irq_grant` stays low.
- R7: In state 01, `irq_ack` returns the code to 11. `irq_req`, `run_req` and `step_req` are ignored in 01, and no second grant is issued.
- R8: In run mode `step_req` moves to 10. In step mode `run_req` moves to 11.
- R9: The flag bits are: bit 0 zero, bit 1 negative, bit 2 carry, bits 7..3 reserved. Each `flag_set` bit sets its flag on the next edge. Flags stay set until cleared.
- R10: An accepted result sets bit 0 if its value is zero, and sets bit 1 if its MSB is 1. A result that is non-zero and positive changes no flag. `res_ready` is low only during reset.
- R11: `flag_clr` clears all eight flags on the next edge. It overrides a `flag_set` or result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| halt_req | input | 1 | Console halt request |
| step_req | input | 1 | Console step-mode request |
| run_req | input | 1 | Console run-mode request |
| irq_req | input | 1 | Interrupt request |
| ie_n | input | 1 | Interrupt enable, active low |
| irq_ack | input | 1 | Negotiation finished |
| flag_set | input | FLAG_W | Per-bit flag set strobes |
| flag_clr | input | 1 | Clear all flags |
| res_valid | input | 1 | Result stream valid |
| res_data | input | DATA_W | Result value |
| res_ready | output | 1 | Result stream ready (high outside reset) |
| st1 | output | 1 | Status bit 1 |
| st0 | output | 1 | Status bit 0 |
| dec_inhibit | output | 1 | Inhibit for decode controllers |
| irq_grant | output | 1 | One-cycle grant to interrupt controller |
| flags | output | FLAG_W | Condition flags |

## Verification
The mode logic is driven with single console requests and with requests that arrive together. These show whether the priority order (halt, then run, then step) is right. The interrupt request is offered in each of the four states and with both enable levels, so a grant taken from halt, step or a disabled run is told apart from a legal one. The same test holds the request high through negotiation to catch a repeated grant. The flag register receives explicit sets, zero, negative and positive results, and a clear that lands together with a set. This separates OR-accumulation, result detection and clear priority.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  typedef enum logic [1:0] {
    OS_HALT  = 2'b00,
    OS_NEGOT = 2'b01,
    OS_STEP  = 2'b10,
    OS_RUN   = 2'b11
  } opstat_e;

  localparam int FLAG_Z = 0;
  localparam int FLAG_N = 1;
  localparam int FLAG_C = 2;
endpackage

// File: rtl/opstat_fsm.sv
module opstat_fsm
  import opstat_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    halt_req,
  input  logic    step_req,
  input  logic    run_req,
  input  logic    irq_req,
  input  logic    ie_n,
  input  logic    irq_ack,
  output opstat_e state,
  output logic    grant
);
  opstat_e nxt;
  logic    accept;

  // an interrupt is taken only from free-running mode with enable low
  assign accept = (state == OS_RUN) && irq_req && !ie_n && !halt_req;

  always_comb begin
    nxt = state;
    if (halt_req) begin
      nxt = OS_HALT;
    end else begin
      unique case (state)
        OS_HALT: begin
          if (run_req)       nxt = OS_RUN;
          else if (step_req) nxt = OS_STEP;
        end
        OS_STEP: begin
          if (run_req) nxt = OS_RUN;
        end
        OS_RUN: begin
          if (accept)        nxt = OS_NEGOT;
          else if (step_req) nxt = OS_STEP;
        end
        OS_NEGOT: begin
          if (irq_ack) nxt = OS_RUN;
        end
        default: nxt = OS_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= OS_HALT;
      grant <= 1'b0;
    end else begin
      state <= nxt;
      grant <= accept;
    end
  end
endmodule

// File: rtl/opstat_result_eval.sv
module opstat_result_eval #(
  parameter int DATA_W = 16
) (
  input  logic              take,
  input  logic [DATA_W-1:0] data,
  output logic              hit_zero,
  output logic              hit_neg
);
  localparam int MSB = DATA_W - 1;

  assign hit_zero = take && (data == '0);
  assign hit_neg  = take && data[MSB];
endmodule

// File: rtl/opstat_flags.sv
module opstat_flags #(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [FLAG_W-1:0] set_vec,
  output logic [FLAG_W-1:0] flags
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)     flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/opstat_arbiter.sv
module opstat_arbiter
  import opstat_pkg::*;
#(
  parameter int FLAG_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic              step_req,
  input  logic              run_req,
  input  logic              irq_req,
  input  logic              ie_n,
  input  logic              irq_ack,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic              flag_clr,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              res_ready,
  output logic              st1,
  output logic              st0,
  output logic              dec_inhibit,
  output logic              irq_grant,
  output logic [FLAG_W-1:0] flags
);
  opstat_e           state;
  logic [1:0]        st_code;
  logic              res_take;
  logic              hit_zero;
  logic              hit_neg;
  logic [FLAG_W-1:0] set_all;

  opstat_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .halt_req(halt_req),
    .step_req(step_req),
    .run_req (run_req),
    .irq_req (irq_req),
    .ie_n    (ie_n),
    .irq_ack (irq_ack),
    .state   (state),
    .grant   (irq_grant)
  );

  assign st_code     = state;
  assign st1         = st_code[1];
  assign st0         = st_code[0];
  assign dec_inhibit = ~st_code[1];

  assign res_ready = ~rst;
  assign res_take  = res_valid && res_ready;

  opstat_result_eval #(.DATA_W(DATA_W)) u_eval (
    .take    (res_take),
    .data    (res_data),
    .hit_zero(hit_zero),
    .hit_neg (hit_neg)
  );

  always_comb begin
    set_all         = flag_set;
    set_all[FLAG_Z] = flag_set[FLAG_Z] | hit_zero;
    set_all[FLAG_N] = flag_set[FLAG_N] | hit_neg;
  end

  opstat_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .clr    (flag_clr),
    .set_vec(set_all),
    .flags  (flags)
  );
endmodule

// File: rtl/opstat_arbiter_chk.sv
module opstat_arbiter_chk #(
  parameter int FLAG_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              halt_req,
  input logic              irq_req,
  input logic              ie_n,
  input logic              irq_ack,
  input logic              flag_clr,
  input logic              st1,
  input logic              st0,
  input logic              dec_inhibit,
  input logic              irq_grant,
  input logic [FLAG_W-1:0] flags
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!st1 && !st0 && flags == '0 && !irq_grant));

  // R3
  halt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> (!st1 && !st0));

  // R4
  grant_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    irq_grant |-> (dec_inhibit && !st1 && st0));

  // R5
  grant_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_grant |-> $past(st1 && st0 && irq_req && !ie_n && !halt_req));

  // R7
  negot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!st1 && st0 && !halt_req && !irq_ack) |=> (!st1 && st0 && !irq_grant));

  // R7
  negot_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (!st1 && st0 && !halt_req && irq_ack) |=> (st1 && st0));

  // R11
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> (flags == '0));

  // R9
  sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_clr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind opstat_arbiter opstat_arbiter_chk #(.FLAG_W(FLAG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .halt_req   (halt_req),
  .irq_req    (irq_req),
  .ie_n       (ie_n),
  .irq_ack    (irq_ack),
  .flag_clr   (flag_clr),
  .st1        (st1),
  .st0        (st0),
  .dec_inhibit(dec_inhibit),
  .irq_grant  (irq_grant),
  .flags      (flags)
);

// File: tb/opstat_arbiter_test.sv
module opstat_arbiter_test;
  localparam int FLAG_W = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              halt_req = 0, step_req = 0, run_req = 0;
  logic              irq_req = 0, ie_n = 1, irq_ack = 0;
  logic [FLAG_W-1:0] flag_set = '0;
  logic              flag_clr = 0;
  logic              res_valid = 0;
  logic [DATA_W-1:0] res_data = '0;
  logic              res_ready, st1, st0, dec_inhibit, irq_grant;
  logic [FLAG_W-1:0] flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  opstat_arbiter #(.FLAG_W(FLAG_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .step_req(step_req),
    .run_req(run_req), .irq_req(irq_req), .ie_n(ie_n), .irq_ack(irq_ack),
    .flag_set(flag_set), .flag_clr(flag_clr), .res_valid(res_valid),
    .res_data(res_data), .res_ready(res_ready), .st1(st1), .st0(st0),
    .dec_inhibit(dec_inhibit), .irq_grant(irq_grant), .flags(flags)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_st(input logic [1:0] exp, input string req);
    chk({st1, st0} === exp, req, int'({st1, st0}), int'(exp));
  endtask

  task automatic clear_inputs();
    halt_req = 0; step_req = 0; run_req = 0; irq_req = 0; irq_ack = 0;
    flag_set = '0; flag_clr = 0; res_valid = 0; res_data = '0;
  endtask

  // one edge: inputs set before the call are sampled, then checked after
  task automatic tick();
    @(posedge clk);
    #1;
    clear_inputs();
  endtask

  task automatic go_state(input logic [1:0] s);
    @(negedge clk); halt_req = 1; tick();
    if (s == 2'b11) begin @(negedge clk); run_req = 1; tick(); end
    if (s == 2'b10) begin @(negedge clk); step_req = 1; tick(); end
  endtask

  task automatic t_reset();
    rst = 1;
    @(negedge clk); res_valid = 1; flag_set = '1; run_req = 1;
    @(posedge clk); #1;
    chk(res_ready == 0, "R10 ready low in reset", res_ready, 0);
    clear_inputs();
    @(negedge clk); rst = 0;
    #1;
    chk_st(2'b00, "R1 reset halt");
    chk(flags == '0, "R1 flags cleared", flags, 0);
    chk(irq_grant == 0, "R1 no grant", irq_grant, 0);
    chk(dec_inhibit == 1, "R4 inhibit in halt", dec_inhibit, 1);
    chk(res_ready == 1, "R10 ready after reset", res_ready, 1);
  endtask

  task automatic t_modes();
    go_state(2'b00);
    @(negedge clk); run_req = 1; tick();
    chk_st(2'b11, "R2 halt to run");
    chk(dec_inhibit == 0, "R4 no inhibit in run", dec_inhibit, 0);
    @(negedge clk); step_req = 1; tick();
    chk_st(2'b10, "R8 run to step");
    chk(dec_inhibit == 0, "R4 no inhibit in step", dec_inhibit, 0);
    @(negedge clk); run_req = 1; tick();
    chk_st(2'b11, "R8 step to run");
    @(negedge clk); halt_req = 1; run_req = 1; step_req = 1; tick();
    chk_st(2'b00, "R3 halt beats run and step");
    @(negedge clk); step_req = 1; tick();
    chk_st(2'b10, "R2 halt to step");
    go_state(2'b00);
    @(negedge clk); step_req = 1; run_req = 1; tick();
    chk_st(2'b11, "R2 run wins over step");
  endtask

  task automatic t_irq_ignored();
    go_state(2'b00);
    @(negedge clk); ie_n = 0; irq_req = 1; tick();
    chk_st(2'b00, "R6 ignored in halt");
    chk(irq_grant == 0, "R6 no grant in halt", irq_grant, 0);
    go_state(2'b10);
    @(negedge clk); ie_n = 0; irq_req = 1; tick();
    chk_st(2'b10, "R6 ignored in step");
    chk(irq_grant == 0, "R6 no grant in step", irq_grant, 0);
    go_state(2'b11);
    @(negedge clk); ie_n = 1; irq_req = 1; tick();
    chk_st(2'b11, "R6 ignored with enable high");
    chk(irq_grant == 0, "R6 no grant with enable high", irq_grant, 0);
  endtask

  task automatic t_irq_accept();
    go_state(2'b11);
    @(negedge clk); ie_n = 0; irq_req = 1; tick();
    chk_st(2'b01, "R5 accepted to negotiation");
    chk(irq_grant == 1, "R5 grant pulse", irq_grant, 1);
    chk(dec_inhibit == 1, "R4 inhibit in negotiation", dec_inhibit, 1);
    @(negedge clk); irq_req = 1; run_req = 1; step_req = 1; tick();
    chk_st(2'b01, "R7 requests ignored in negotiation");
    chk(irq_grant == 0, "R7 no second grant", irq_grant, 0);
    @(negedge clk); irq_ack = 1; tick();
    chk_st(2'b11, "R7 ack returns to run");
    chk(irq_grant == 0, "R7 grant low after ack", irq_grant, 0);
    @(negedge clk); irq_req = 1; tick();
    chk_st(2'b01, "R5 re-accepted");
    @(negedge clk); halt_req = 1; irq_ack = 1; tick();
    chk_st(2'b00, "R3 halt beats ack");
    ie_n = 1;
  endtask

  task automatic t_flags();
    @(negedge clk); flag_clr = 1; tick();
    chk(flags == 8'h00, "R11 start clear", flags, 8'h00);
    @(negedge clk); flag_set = 8'h04; tick();
    chk(flags == 8'h04, "R9 carry set", flags, 8'h04);
    @(negedge clk); flag_set = 8'h80; tick();
    chk(flags == 8'h84, "R9 reserved set, sticky", flags, 8'h84);
    @(negedge clk); res_valid = 1; res_data = 16'h0005; tick();
    chk(flags == 8'h84, "R10 positive result no change", flags, 8'h84);
    @(negedge clk); res_valid = 1; res_data = 16'h0000; tick();
    chk(flags == 8'h85, "R10 zero result", flags, 8'h85);
    @(negedge clk); res_valid = 1; res_data = 16'h8001; tick();
    chk(flags == 8'h87, "R10 negative result", flags, 8'h87);
    @(negedge clk); res_data = 16'h0000; tick();
    chk(flags == 8'h87, "R10 no valid no effect", flags, 8'h87);
    @(negedge clk); flag_clr = 1; flag_set = 8'h10; res_valid = 1; tick();
    chk(flags == 8'h00, "R11 clear beats set", flags, 8'h00);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_irq_ignored();
    t_irq_accept();
    t_flags();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule